// File: doc/BRIEF.md
# Relocatable Local SRAM with Base and Attribute Register

This block is a single-cycle static RAM that sits next to a processor core. It runs in parallel with the cache path. One configuration register decides whether the RAM answers at all, where it sits in the 32-bit address space, whether stores to it are allowed, and which access types it serves. Every access carries a tag saying whether it is an instruction fetch or a data operand. Both the RAM and the cache see the access in the same cycle.

When an access falls inside the RAM window, the RAM returns the read data one cycle later. In that same cycle it raises a discard strobe so that the cache result is dropped. Access types that are masked off never enable the array, which keeps the array idle to save power. A store that hits the window while write protection is on leaves the array untouched and raises a one-cycle error pulse. The block never clears the array itself: software loads the contents after it has enabled the window.

Top module: `reloc_sram`

## Requirements
- R1: After reset the configuration register reads as zero, so the valid bit is clear and no access produces a discard strobe.
- R2: The register layout is as follows. Bit 0 is valid, bit 1 is write-protect, bit 2 masks instruction fetches and bit 3 masks data operands. Bits 31:14 hold the base address. All other bits are not stored and read back as zero.
- R3: An access hits when the valid bit is set, its type is not masked, and address bits 31:14 equal the base field. A read hit raises `cache_discard` in the next cycle, with `rd_data` holding the word at index addr[13:2].
- R4: An access whose address lies outside the 16 KiB window never raises `cache_discard`. This holds for addresses just above the window and just below it.
- R5: An instruction fetch is treated as a miss while the fetch mask is set. A data access is treated as a miss while the data mask is set. A masked store leaves the array unchanged and raises no error.
- R6: A store that hits while write-protect is set leaves the word unchanged and raises `acc_err` for exactly one cycle, in the cycle after the store. A store made without write protection raises no error and no discard.
- R7: A store updates only the byte lanes whose `acc_be` bit is set, where lane b is data bits 8b+7:8b. This gives 8-, 16- and 32-bit stores.
- R8: Reads have one cycle of latency. Reads issued in consecutive cycles each return their own word in the cycle after they were issued.
- R9: A register write takes effect for the access in the following cycle. An access issued in the same cycle as the register write is decoded against the old value. After relocation the old window misses and the new window returns the retained contents.
- R10: Reset does not alter the array contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the configuration register |
| cfg_wdata | input | 32 | New configuration register value |
| cfg_rdata | output | 32 | Current configuration register value |
| acc_req | input | 1 | Access request presented in this cycle |
| acc_is_fetch | input | 1 | 1 = instruction fetch, 0 = data operand |
| acc_we | input | 1 | 1 = store, 0 = read |
| acc_be | input | 4 | Byte-lane enables for stores |
| acc_addr | input | 32 | Byte address of the access |
| acc_wdata | input | 32 | Store data |
| rd_data | output | 32 | Read data, valid while `cache_discard` is high |
| cache_discard | output | 1 | Read hit in the previous cycle; the cache result must be dropped |
| acc_err | output | 1 | One-cycle pulse after a store blocked by write protection |

## Verification
A vector table first sets up the window and then mixes full-word and partial-lane stores with read-backs. This separates correct lane merging from whole-word overwrites. It also probes the first and last words of the window and the addresses just outside it, which catches off-by-one errors in the base compare. Directed sequences then toggle each attribute bit in turn: fetch mask, data mask and write protect. For each one, a later unmasked read shows whether the array was touched while that bit was set. A register write is issued in the same cycle as an access to separate old-value from new-value decode. A mid-run reset shows that the register clears while the data survives.

// File: rtl/lmem_pkg.sv
package lmem_pkg;

    localparam int unsigned CFG_VALID_BIT = 0;
    localparam int unsigned CFG_WP_BIT    = 1;
    localparam int unsigned CFG_MFETCH_BIT = 2;
    localparam int unsigned CFG_MDATA_BIT = 3;

    typedef struct packed {
        logic mask_data;
        logic mask_fetch;
        logic wp;
        logic valid;
    } lm_attr_t;

    typedef struct packed {
        logic discard;
        logic err;
    } lm_resp_t;

endpackage

// File: rtl/lmem_cfg_reg.sv
module lmem_cfg_reg
    import lmem_pkg::*;
#(
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned BASE_LSB = 14
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_we,
    input  logic [ADDR_W-1:0]          cfg_wdata,
    output logic [ADDR_W-BASE_LSB-1:0] base_q,
    output lm_attr_t                   attr_q,
    output logic [ADDR_W-1:0]          cfg_rdata
);
    localparam int unsigned BASE_W = ADDR_W - BASE_LSB;

    typedef struct packed {
        logic [BASE_W-1:0] base;
        lm_attr_t          attr;
    } cfg_t;

    cfg_t reg_d, reg_q;

    always_comb begin
        reg_d = reg_q;
        if (cfg_we) begin
            reg_d.base            = cfg_wdata[ADDR_W-1:BASE_LSB];
            reg_d.attr.valid      = cfg_wdata[CFG_VALID_BIT];
            reg_d.attr.wp         = cfg_wdata[CFG_WP_BIT];
            reg_d.attr.mask_fetch = cfg_wdata[CFG_MFETCH_BIT];
            reg_d.attr.mask_data  = cfg_wdata[CFG_MDATA_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) reg_q <= '0;
        else        reg_q <= reg_d;
    end

    always_comb begin
        cfg_rdata                      = '0;
        cfg_rdata[ADDR_W-1:BASE_LSB]   = reg_q.base;
        cfg_rdata[CFG_VALID_BIT]       = reg_q.attr.valid;
        cfg_rdata[CFG_WP_BIT]          = reg_q.attr.wp;
        cfg_rdata[CFG_MFETCH_BIT]      = reg_q.attr.mask_fetch;
        cfg_rdata[CFG_MDATA_BIT]       = reg_q.attr.mask_data;
    end

    assign base_q = reg_q.base;
    assign attr_q = reg_q.attr;
endmodule

// File: rtl/lmem_decode.sv
module lmem_decode
    import lmem_pkg::*;
#(
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned BASE_LSB = 14
) (
    input  logic [ADDR_W-BASE_LSB-1:0] base_q,
    input  lm_attr_t                   attr_q,
    input  logic                       acc_req,
    input  logic                       acc_is_fetch,
    input  logic                       acc_we,
    input  logic [ADDR_W-1:0]          acc_addr,
    output logic                       hit,
    output logic                       arr_rd,
    output logic                       arr_wr,
    output logic                       blocked
);
    logic type_masked;
    logic in_window;

    always_comb begin
        type_masked = acc_is_fetch ? attr_q.mask_fetch : attr_q.mask_data;
        in_window   = (acc_addr[ADDR_W-1:BASE_LSB] == base_q);
        hit         = acc_req && attr_q.valid && !type_masked && in_window;
        arr_rd      = hit && !acc_we;
        arr_wr      = hit && acc_we && !attr_q.wp;
        blocked     = hit && acc_we && attr_q.wp;
    end
endmodule

// File: rtl/lmem_array.sv
module lmem_array #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DEPTH  = 4096
) (
    input  logic                     clk,
    input  logic                     arr_rd,
    input  logic                     arr_wr,
    input  logic [$clog2(DEPTH)-1:0] idx,
    input  logic [DATA_W/8-1:0]      be,
    input  logic [DATA_W-1:0]        wdata,
    output logic [DATA_W-1:0]        rdata
);
    localparam int unsigned LANES = DATA_W / 8;

    logic [DATA_W-1:0] mem [DEPTH];

    for (genvar b = 0; b < LANES; b++) begin : g_lane
        always_ff @(posedge clk) begin
            if (arr_wr && be[b]) mem[idx][8*b +: 8] <= wdata[8*b +: 8];
        end
    end

    always_ff @(posedge clk) begin
        if (arr_rd) rdata <= mem[idx];
    end
endmodule

// File: rtl/reloc_sram.sv
module reloc_sram
    import lmem_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DEPTH  = 4096
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [ADDR_W-1:0]   cfg_wdata,
    output logic [ADDR_W-1:0]   cfg_rdata,
    input  logic                acc_req,
    input  logic                acc_is_fetch,
    input  logic                acc_we,
    input  logic [DATA_W/8-1:0] acc_be,
    input  logic [ADDR_W-1:0]   acc_addr,
    input  logic [DATA_W-1:0]   acc_wdata,
    output logic [DATA_W-1:0]   rd_data,
    output logic                cache_discard,
    output logic                acc_err
);
    localparam int unsigned LANES    = DATA_W / 8;
    localparam int unsigned OFF_W    = $clog2(LANES);
    localparam int unsigned IDX_W    = $clog2(DEPTH);
    localparam int unsigned BASE_LSB = OFF_W + IDX_W;
    localparam int unsigned BASE_W   = ADDR_W - BASE_LSB;

    logic [BASE_W-1:0] base_q;
    lm_attr_t          attr_q;
    logic              hit, arr_rd, arr_wr, blocked;
    lm_resp_t          resp_d, resp_q;

    lmem_cfg_reg #(.ADDR_W(ADDR_W), .BASE_LSB(BASE_LSB)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .base_q    (base_q),
        .attr_q    (attr_q),
        .cfg_rdata (cfg_rdata)
    );

    lmem_decode #(.ADDR_W(ADDR_W), .BASE_LSB(BASE_LSB)) u_dec (
        .base_q       (base_q),
        .attr_q       (attr_q),
        .acc_req      (acc_req),
        .acc_is_fetch (acc_is_fetch),
        .acc_we       (acc_we),
        .acc_addr     (acc_addr),
        .hit          (hit),
        .arr_rd       (arr_rd),
        .arr_wr       (arr_wr),
        .blocked      (blocked)
    );

    lmem_array #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_arr (
        .clk    (clk),
        .arr_rd (arr_rd),
        .arr_wr (arr_wr),
        .idx    (acc_addr[BASE_LSB-1:OFF_W]),
        .be     (acc_be),
        .wdata  (acc_wdata),
        .rdata  (rd_data)
    );

    always_comb begin
        resp_d         = '0;
        resp_d.discard = arr_rd;
        resp_d.err     = blocked;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) resp_q <= '0;
        else        resp_q <= resp_d;
    end

    assign cache_discard = resp_q.discard;
    assign acc_err       = resp_q.err;

    logic unused_hit;
    assign unused_hit = hit;
endmodule

// File: rtl/reloc_sram_chk.sv
module reloc_sram_chk
    import lmem_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] cfg_rdata,
    input logic              acc_req,
    input logic              acc_is_fetch,
    input logic              acc_we,
    input logic              cache_discard,
    input logic              acc_err
);
    assert_no_hit_invalid_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && !cfg_rdata[CFG_VALID_BIT]) |=> !cache_discard);

    assert_discard_after_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cache_discard |-> $past(acc_req && !acc_we));

    assert_fetch_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && acc_is_fetch && cfg_rdata[CFG_MFETCH_BIT]) |=> !cache_discard);

    assert_data_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && !acc_is_fetch && cfg_rdata[CFG_MDATA_BIT]) |=> (!cache_discard && !acc_err));

    assert_err_needs_wp_R6: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err |-> $past(acc_req && acc_we && cfg_rdata[CFG_WP_BIT]));

    assert_err_not_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_err && cache_discard));
endmodule

bind reloc_sram reloc_sram_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_rdata     (cfg_rdata),
    .acc_req       (acc_req),
    .acc_is_fetch  (acc_is_fetch),
    .acc_we        (acc_we),
    .cache_discard (cache_discard),
    .acc_err       (acc_err)
);

// File: tb/reloc_sram_bench.sv
`timescale 1ns/1ps
module reloc_sram_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        acc_req = 1'b0, acc_is_fetch = 1'b0, acc_we = 1'b0;
    logic [3:0]  acc_be = '0;
    logic [31:0] acc_addr = '0, acc_wdata = '0;
    logic [31:0] rd_data;
    logic        cache_discard, acc_err;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    reloc_sram u_reloc_sram (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .acc_req(acc_req), .acc_is_fetch(acc_is_fetch),
        .acc_we(acc_we), .acc_be(acc_be), .acc_addr(acc_addr),
        .acc_wdata(acc_wdata), .rd_data(rd_data),
        .cache_discard(cache_discard), .acc_err(acc_err)
    );

    typedef struct packed {
        logic [1:0]  tag;    // 0:R3 1:R4 2:R7
        logic        fetch;
        logic        we;
        logic [3:0]  be;
        logic [31:0] addr;
        logic [31:0] wdata;
        logic        hit;
        logic [31:0] rdata;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'b0, 1'b1, 4'hF, 32'h2000_0000, 32'h1122_3344, 1'b0, 32'h0},
        '{2'd0, 1'b0, 1'b0, 4'h0, 32'h2000_0000, 32'h0,         1'b1, 32'h1122_3344},
        '{2'd2, 1'b0, 1'b1, 4'h1, 32'h2000_0000, 32'hAAAA_AAAA, 1'b0, 32'h0},
        '{2'd2, 1'b0, 1'b0, 4'h0, 32'h2000_0000, 32'h0,         1'b1, 32'h1122_33AA},
        '{2'd2, 1'b0, 1'b1, 4'hC, 32'h2000_0000, 32'hBBBB_0000, 1'b0, 32'h0},
        '{2'd2, 1'b0, 1'b0, 4'h0, 32'h2000_0000, 32'h0,         1'b1, 32'hBBBB_33AA},
        '{2'd0, 1'b0, 1'b1, 4'hF, 32'h2000_3FFC, 32'hDEAD_BEEF, 1'b0, 32'h0},
        '{2'd0, 1'b1, 1'b0, 4'h0, 32'h2000_3FFC, 32'h0,         1'b1, 32'hDEAD_BEEF},
        '{2'd1, 1'b0, 1'b0, 4'h0, 32'h2000_4000, 32'h0,         1'b0, 32'h0},
        '{2'd1, 1'b1, 1'b0, 4'h0, 32'h1FFF_FFFC, 32'h0,         1'b0, 32'h0},
        '{2'd0, 1'b0, 1'b1, 4'hF, 32'h2000_0004, 32'h0102_0304, 1'b0, 32'h0},
        '{2'd0, 1'b0, 1'b0, 4'h0, 32'h2000_0004, 32'h0,         1'b1, 32'h0102_0304}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one access at a negedge, return at the negedge after the capturing edge.
    task automatic access(input logic f, input logic w, input logic [3:0] be,
                          input logic [31:0] a, input logic [31:0] d);
        acc_req = 1'b1; acc_is_fetch = f; acc_we = w; acc_be = be;
        acc_addr = a; acc_wdata = d;
        @(posedge clk); @(negedge clk);
        acc_req = 1'b0; acc_we = 1'b0;
    endtask

    task automatic cfg_write(input logic [31:0] v);
        cfg_we = 1'b1; cfg_wdata = v;
        @(posedge clk); @(negedge clk);
        cfg_we = 1'b0;
    endtask

    initial begin
        #200us;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state, register cleared and no response even for address 0 == base 0
        chk("R1 cfg after reset", cfg_rdata, 32'h0);
        access(1'b0, 1'b0, 4'h0, 32'h0000_0000, 32'h0);
        chk("R1 no discard when invalid", {31'b0, cache_discard}, 32'h0);

        // R2: layout and unstored bits
        cfg_write(32'h2000_3FF0);
        chk("R2 unstored bits read zero", cfg_rdata, 32'h2000_0000);
        cfg_write(32'h2000_000F);
        chk("R2 attribute bits", cfg_rdata, 32'h2000_000F);
        cfg_write(32'h2000_0001);
        chk("R2 valid only", cfg_rdata, 32'h2000_0001);

        // Table walk: R3, R4, R7
        for (int i = 0; i < NV; i++) begin
            string t;
            case (VECS[i].tag)
                2'd0:    t = "R3";
                2'd1:    t = "R4";
                default: t = "R7";
            endcase
            access(VECS[i].fetch, VECS[i].we, VECS[i].be, VECS[i].addr, VECS[i].wdata);
            chk($sformatf("%s vec %0d discard", t, i), {31'b0, cache_discard}, {31'b0, VECS[i].hit});
            if (VECS[i].we) chk($sformatf("R6 vec %0d no err unprotected", i), {31'b0, acc_err}, 32'h0);
            if (VECS[i].hit) chk($sformatf("%s vec %0d data", t, i), rd_data, VECS[i].rdata);
        end

        // R8: back-to-back reads
        acc_req = 1'b1; acc_is_fetch = 1'b0; acc_we = 1'b0; acc_addr = 32'h2000_0004;
        @(posedge clk); @(negedge clk);
        chk("R8 first read", rd_data, 32'h0102_0304);
        chk("R8 first discard", {31'b0, cache_discard}, 32'h1);
        acc_addr = 32'h2000_3FFC;
        @(posedge clk); @(negedge clk);
        acc_req = 1'b0;
        chk("R8 second read", rd_data, 32'hDEAD_BEEF);
        chk("R8 second discard", {31'b0, cache_discard}, 32'h1);
        @(posedge clk); @(negedge clk);
        chk("R8 discard drops", {31'b0, cache_discard}, 32'h0);

        // R5: fetch mask
        cfg_write(32'h2000_0005);
        access(1'b1, 1'b0, 4'h0, 32'h2000_0004, 32'h0);
        chk("R5 masked fetch misses", {31'b0, cache_discard}, 32'h0);
        access(1'b0, 1'b0, 4'h0, 32'h2000_0004, 32'h0);
        chk("R5 data still hits", rd_data, 32'h0102_0304);
        // R5: data mask
        cfg_write(32'h2000_0009);
        access(1'b0, 1'b1, 4'hF, 32'h2000_0004, 32'hFFFF_FFFF);
        chk("R5 masked store no err", {31'b0, acc_err}, 32'h0);
        access(1'b0, 1'b0, 4'h0, 32'h2000_0004, 32'h0);
        chk("R5 masked data read misses", {31'b0, cache_discard}, 32'h0);
        cfg_write(32'h2000_0001);
        access(1'b0, 1'b0, 4'h0, 32'h2000_0004, 32'h0);
        chk("R5 masked store left word", rd_data, 32'h0102_0304);

        // R6: write protect
        cfg_write(32'h2000_0003);
        access(1'b0, 1'b1, 4'hF, 32'h2000_0004, 32'h0);
        chk("R6 err pulse", {31'b0, acc_err}, 32'h1);
        chk("R6 no discard on store", {31'b0, cache_discard}, 32'h0);
        @(posedge clk); @(negedge clk);
        chk("R6 err one cycle", {31'b0, acc_err}, 32'h0);
        access(1'b0, 1'b0, 4'h0, 32'h2000_0004, 32'h0);
        chk("R6 protected word unchanged", rd_data, 32'h0102_0304);
        cfg_write(32'h2000_0001);

        // R9: register write and access in the same cycle use the old value
        cfg_we = 1'b1; cfg_wdata = 32'h4000_0001;
        acc_req = 1'b1; acc_is_fetch = 1'b0; acc_we = 1'b0; acc_addr = 32'h2000_0004;
        @(posedge clk); @(negedge clk);
        cfg_we = 1'b0; acc_req = 1'b0;
        chk("R9 same-cycle uses old base", {31'b0, cache_discard}, 32'h1);
        access(1'b0, 1'b0, 4'h0, 32'h2000_0004, 32'h0);
        chk("R9 old window misses", {31'b0, cache_discard}, 32'h0);
        access(1'b1, 1'b0, 4'h0, 32'h4000_0004, 32'h0);
        chk("R9 new window discard", {31'b0, cache_discard}, 32'h1);
        chk("R9 new window data", rd_data, 32'h0102_0304);

        // R10: reset keeps contents
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 cfg cleared", cfg_rdata, 32'h0);
        cfg_write(32'h2000_0001);
        access(1'b0, 1'b0, 4'h0, 32'h2000_3FFC, 32'h0);
        chk("R10 contents kept", rd_data, 32'hDEAD_BEEF);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule